// File: doc/BRIEF.md
# Warp Cache-Line Access Coalescer

This block takes one load request for a whole warp of parallel threads. The request carries a byte address for each thread and a mask of the threads that are active. The block turns it into a sequence of memory requests, one for each distinct 128-byte cache line that the active threads touch. Each request it emits carries the aligned line address and a mask of the threads that the line serves. Threads that share a line are merged into one access. Only accesses to different lines are serialized, so a warp in which every thread uses the same address costs a single access.

Both the warp input and the line-request output use a valid/ready handshake. On each step the lowest-numbered thread that is still pending chooses the line. Every pending thread that maps to that line is then served and cleared. The final request of a warp is flagged. After that request is taken, a one-cycle completion pulse follows. A warp with no active threads completes at once, with the pulse and no requests. Returning data, the cache and the address arithmetic belong to the surrounding pipeline.

Top module: `warp_line_coalescer`

## Requirements
- R1: After reset, `out_valid` and `done` are 0 and `in_ready` is 1.
- R2: `out_line` equals the leading thread's address with its low log2(LINE_BYTES) bits (7 bits by default) cleared, so it is always line-aligned.
- R3: Requests of one warp appear in ascending order of their lowest-numbered served thread. That thread is the lowest-numbered active thread not yet served.
- R4: `out_mask` has bit t set exactly for the active, not yet served threads whose address lies in the same line as the leader. It is never zero while `out_valid` is 1.
- R5: A warp produces exactly one request per distinct line among its active threads. The masks of its requests are disjoint and their union equals the active mask.
- R6: A warp whose active threads all share one address produces exactly one request, and that request has `out_last` = 1.
- R7: A warp accepted with an all-zero `in_mask` produces no request. `done` is 1 in the cycle after acceptance.
- R8: `out_last` is 1 only on the final request of a warp. `in_ready` is 0 from acceptance of a non-empty warp until the cycle after its last request is taken.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_line`, `out_mask` and `out_last` hold their values into the next cycle.
- R10: `done` is 1 for exactly the cycle after the final request is taken, and in that cycle `out_valid` is 0 and `in_ready` is 1.
- R11: Addresses of inactive threads have no effect: such a thread never appears in `out_mask`, even when its address shares a line with active threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Warp request offered |
| in_ready | output | 1 | Block idle, able to take a warp |
| in_mask | input | THREADS | Active-thread mask, bit t for thread t |
| in_addr | input | THREADS*ADDR_W | Byte addresses, thread t at bits [t*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | Line request offered |
| out_ready | input | 1 | Consumer takes the line request |
| out_line | output | ADDR_W | Line-aligned address of the request |
| out_mask | output | THREADS | Threads served by this request |
| out_last | output | 1 | Final request of the current warp |
| done | output | 1 | One-cycle pulse: warp fully issued |

## Verification
The bench builds the block with its defaults: 32 threads, 32-bit addresses and 128-byte lines. That makes every case from a single merged access up to 32 fully serialized lines reachable within one warp. Random warps draw their addresses from a small pool of lines with random offsets, so merges across scattered thread numbers are common. Directed warps add an empty mask, the two bytes on either side of a line boundary, inactive threads that alias an active line, and lines in an order that is the reverse of thread order. Random backpressure on `out_ready` keeps requests stalled for several cycles.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } coal_state_e;
endpackage

// File: rtl/coal_leader_pick.sv
module coal_leader_pick #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] req,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
   parameter int unsigned THREADS = 32,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned OFFS_W  = 7
) (
   input  logic [THREADS*ADDR_W-1:0] addr_flat,
   input  logic [ADDR_W-1:0]         ref_addr,
   input  logic [THREADS-1:0]        cand,
   output logic [THREADS-1:0]        hit
);
   localparam int unsigned TAG_W = ADDR_W - OFFS_W;

   logic [TAG_W-1:0] ref_tag;
   assign ref_tag = ref_addr[ADDR_W-1:OFFS_W];

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic [ADDR_W-1:0] a;
      assign a      = addr_flat[t*ADDR_W +: ADDR_W];
      assign hit[t] = cand[t] && (a[ADDR_W-1:OFFS_W] == ref_tag);
   end
endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer
   import coal_pkg::*;
#(
   parameter int unsigned THREADS    = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 128
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [THREADS-1:0]        in_mask,
   input  logic [THREADS*ADDR_W-1:0] in_addr,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [ADDR_W-1:0]         out_line,
   output logic [THREADS-1:0]        out_mask,
   output logic                      out_last,
   output logic                      done
);
   localparam int unsigned OFFS_W = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W  = (THREADS > 1) ? $clog2(THREADS) : 1;
   localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'((64'd1 << OFFS_W) - 64'd1);

   if (THREADS < 2) begin : g_bad_threads
      $error("warp_line_coalescer: THREADS must be at least 2");
   end
   if ((1 << OFFS_W) != LINE_BYTES || OFFS_W == 0) begin : g_bad_line
      $error("warp_line_coalescer: LINE_BYTES must be a power of two above 1");
   end
   if (OFFS_W >= ADDR_W) begin : g_bad_addr
      $error("warp_line_coalescer: ADDR_W must exceed the line offset width");
   end

   coal_state_e               state_q;
   logic [THREADS-1:0]        pend_q;
   logic [THREADS*ADDR_W-1:0] addr_q;
   logic                      done_q;

   logic [IDX_W-1:0]   lead_idx;
   logic               lead_any;
   logic [ADDR_W-1:0]  lead_addr;
   logic [THREADS-1:0] hit;
   logic [THREADS-1:0] remain;
   logic               accept;
   logic               fire;

   coal_leader_pick #(.WIDTH(THREADS)) u_pick (
      .req (pend_q),
      .idx (lead_idx),
      .any (lead_any)
   );

   assign lead_addr = addr_q[lead_idx*ADDR_W +: ADDR_W];

   coal_line_match #(
      .THREADS (THREADS),
      .ADDR_W  (ADDR_W),
      .OFFS_W  (OFFS_W)
   ) u_match (
      .addr_flat (addr_q),
      .ref_addr  (lead_addr),
      .cand      (pend_q),
      .hit       (hit)
   );

   assign remain    = pend_q & ~hit;
   assign in_ready  = (state_q == ST_IDLE);
   assign out_valid = (state_q == ST_BUSY) && lead_any;
   assign out_line  = lead_addr & ~OFFS_MASK;
   assign out_mask  = hit;
   assign out_last  = out_valid && (remain == '0);
   assign done      = done_q;

   assign accept = in_valid && in_ready;
   assign fire   = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            addr_q <= in_addr;
            pend_q <= in_mask;
            if (in_mask == '0) begin
               done_q <= 1'b1;
            end else begin
               state_q <= ST_BUSY;
            end
         end else if (fire) begin
            pend_q <= remain;
            if (remain == '0) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
   parameter int unsigned THREADS    = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [THREADS-1:0] in_mask,
   input logic               out_valid,
   input logic               out_ready,
   input logic [ADDR_W-1:0]  out_line,
   input logic [THREADS-1:0] out_mask,
   input logic               out_last,
   input logic               done
);
   localparam int unsigned OFFS_W = $clog2(LINE_BYTES);

   a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_line[OFFS_W-1:0] == '0));

   a_r3_more_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> out_valid);

   a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mask != '0));

   a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_mask == '0)) |=> (done && !out_valid));

   a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_line)
                                     && $stable(out_mask) && $stable(out_last)));

   a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (done && in_ready && !out_valid));

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid);
endmodule

bind warp_line_coalescer coal_checker #(
   .THREADS    (THREADS),
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_mask   (in_mask),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_line  (out_line),
   .out_mask  (out_mask),
   .out_last  (out_last),
   .done      (done)
);

// File: tb/warp_line_coalescer_test.sv
module warp_line_coalescer_test;
   localparam int unsigned THREADS = 32;
   localparam int unsigned ADDR_W  = 32;
   localparam int unsigned LINE_B  = 128;
   localparam int unsigned OFFS    = 7;
   localparam time         CLK_PERIOD = 10ns;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      in_valid = 1'b0;
   logic                      in_ready;
   logic [THREADS-1:0]        in_mask = '0;
   logic [THREADS*ADDR_W-1:0] in_addr = '0;
   logic                      out_valid;
   logic                      out_ready = 1'b0;
   logic [ADDR_W-1:0]         out_line;
   logic [THREADS-1:0]        out_mask;
   logic                      out_last;
   logic                      done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [ADDR_W-1:0]  ta [THREADS];
   logic [ADDR_W-1:0]  exp_line [THREADS];
   logic [THREADS-1:0] exp_mask [THREADS];
   int                 exp_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_line_coalescer #(
      .THREADS(THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_B)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_mask(in_mask), .in_addr(in_addr), .out_valid(out_valid),
      .out_ready(out_ready), .out_line(out_line), .out_mask(out_mask),
      .out_last(out_last), .done(done)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference: lowest pending thread picks the line, all pending threads in it are served.
   task automatic model(input logic [THREADS-1:0] m);
      logic [THREADS-1:0] pend;
      logic [ADDR_W-1:0]  tag;
      pend = m;
      exp_cnt = 0;
      while (pend != '0) begin
         int lead;
         lead = 0;
         for (int i = THREADS - 1; i >= 0; i--) if (pend[i]) lead = i;
         tag = ta[lead] >> OFFS;
         exp_line[exp_cnt] = tag << OFFS;
         exp_mask[exp_cnt] = '0;
         for (int j = 0; j < THREADS; j++) begin
            if (pend[j] && ((ta[j] >> OFFS) == tag)) begin
               exp_mask[exp_cnt][j] = 1'b1;
               pend[j] = 1'b0;
            end
         end
         exp_cnt++;
      end
   endtask

   task automatic run_warp(input logic [THREADS-1:0] m);
      int k;
      model(m);
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 idle before warp", 64'(in_ready), 64'd1);
      in_valid = 1'b1;
      in_mask  = m;
      for (int t = 0; t < THREADS; t++) in_addr[t*ADDR_W +: ADDR_W] = ta[t];
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (exp_cnt == 0) begin
         chk(done == 1'b1, "R7 done after empty warp", 64'(done), 64'd1);
         chk(out_valid == 1'b0, "R7 no request for empty warp", 64'(out_valid), 64'd0);
         return;
      end
      k = 0;
      while (k < exp_cnt) begin
         chk(out_valid == 1'b1, "R5 request pending", 64'(out_valid), 64'd1);
         if (!out_valid) break;
         chk(in_ready == 1'b0, "R8 busy blocks input", 64'(in_ready), 64'd0);
         out_ready = (($urandom % 4) != 0);
         if (out_ready) begin
            chk(out_line == exp_line[k], "R2 line address", 64'(out_line), 64'(exp_line[k]));
            chk(out_mask == exp_mask[k], "R4 thread mask", 64'(out_mask), 64'(exp_mask[k]));
            chk(out_last == (k == exp_cnt - 1), "R8 last flag", 64'(out_last),
                64'(k == exp_cnt - 1));
            k++;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(done == 1'b1, "R10 done after last", 64'(done), 64'd1);
      chk(out_valid == 1'b0, "R5 no extra request", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R10 ready after warp", 64'(in_ready), 64'd1);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] pool [8];
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);
      chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
      chk(in_ready == 1'b1, "R1 reset in_ready", 64'(in_ready), 64'd1);
      rst_n = 1'b1;

      // R6: every thread on one address
      for (int t = 0; t < THREADS; t++) ta[t] = 32'h0000_1234;
      model('1);
      chk(exp_cnt == 1, "R6 model single access", 64'(exp_cnt), 64'd1);
      run_warp('1);

      // R7: empty mask
      run_warp('0);

      // R2: bytes on either side of a line boundary; R11: inactive threads alias line 0
      for (int t = 0; t < THREADS; t++) ta[t] = 32'h0000_0010;
      ta[0] = 32'h0000_007F;
      ta[1] = 32'h0000_0080;
      run_warp(32'h0000_0003);

      // R3: line order reversed against thread order
      for (int t = 0; t < THREADS; t++) ta[t] = 32'(THREADS - 1 - t) * LINE_B + 32'(t);
      run_warp('1);

      // single active thread at the top
      for (int t = 0; t < THREADS; t++) ta[t] = 32'hFFFF_FF00 + 32'(t);
      run_warp(32'h8000_0000);

      // R5 / R11: random warps over a small pool of lines
      for (int w = 0; w < 40; w++) begin
         int nl;
         logic [THREADS-1:0] m;
         nl = 1 + ($urandom % 8);
         for (int p = 0; p < 8; p++) pool[p] = $urandom & ~32'(LINE_B - 1);
         for (int t = 0; t < THREADS; t++)
            ta[t] = pool[$urandom % nl] | 32'($urandom % LINE_B);
         m = ((w % 5) == 0) ? '1 : THREADS'($urandom);
         run_warp(m);
      end

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule